// File: doc/BRIEF.md
# Cyclic Ring Power Unit

This block raises a binary polynomial g(x) to a power k in the ring of polynomials over GF(2) taken modulo x^N + 1 (N = 9 by default). In this ring, x^N equals 1, so multiplying by x^i is a cyclic left rotation of the N-bit word by i places. Reduction comes free with the rotation, and there is no divider. Each multiplication by g(x) is built as the XOR of rotated copies of the running value, one for each set bit of the generator. One generator bit is handled per clock.

A caller drives the generator and the exponent and pulses `start` for one cycle. The block captures both operands, sets its running value to the unit polynomial 1, and applies k factors of the generator. It then publishes the result with a one-cycle `done` pulse. The result stays on the output until the next run finishes.

The controller has three states:
- `ST_IDLE` moves to `ST_MUL` when `start` is accepted with k ≠ 0, and to `ST_FIN` when `start` is accepted with k = 0.
- `ST_MUL` stays in place for each generator bit. It moves to `ST_FIN` when the bit index is N−1 and the k-th factor has been applied.
- `ST_FIN` always returns to `ST_IDLE`, and in doing so raises `done` and loads the result.

Top module: `cyc_ring_power`

## Requirements
- R1: After reset, `result` is all zeros and `done` is low.
- R2: An exponent of 0 yields the unit polynomial, `result` = 000000001 (only bit 0 set).
- R3: An exponent of 1 returns the captured generator unchanged.
- R4: `result` equals gen^k reduced modulo x^N+1 over GF(2). Bit i of each word is the coefficient of x^i. For generator 010101101: k=2 gives 001110011 and k=7 gives 000010000.
- R5: Generator 010101101 has order 63 in the ring: k=63 gives 000000001, k=14 gives 100000000, and k=21 gives 000001000.
- R6: Counting the clock edge that accepts `start` as edge 0, `done` is high after edge k·N+1 and not before.
- R7: `done` is high for exactly one cycle per run.
- R8: `result` changes only on the edge that raises `done`. Between runs, changes on `gen_in` or `exp_in` do not alter it.
- R9: `start` is ignored while a run is in `ST_MUL` or `ST_FIN`; operands seen then do not affect the result or the timing. A `start` in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; sampled only in `ST_IDLE` |
| gen_in | input | N | Generator polynomial, bit i = coefficient of x^i |
| exp_in | input | KW | Exponent k (KW = 6) |
| result | output | N | Last computed power, held between runs |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
Two things can happen in one cycle: a new `start` can arrive while the previous run is in its final `ST_MUL` or `ST_FIN` cycle, or it can arrive in the same cycle as `done`. The bench holds `start` high for the whole length of several runs. It then judges from the spacing of the `done` pulses (k·N+2 cycles apart) that the request was ignored until `ST_IDLE` and taken in the `done` cycle itself. A separate run drives back-to-back starts from the `done` cycle and checks the new result and latency against a software model of the ring product.

// File: rtl/cyc_pow_pkg.sv
package cyc_pow_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_FIN  = 2'd2
    } pow_state_e;
endpackage

// File: rtl/cyc_rot_term.sv
// Partial product: the running value rotated left by the current bit index,
// gated by the generator bit at that index. Rotation is reduction mod x^N+1.
module cyc_rot_term #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic [N-1:0]  value,
    input  logic [N-1:0]  gen_mask,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  term
);
    logic [N-1:0] rot [N];

    for (genvar r = 0; r < N; r++) begin : g_rot
        if (r == 0) begin : g_id
            assign rot[r] = value;
        end else begin : g_shift
            assign rot[r] = {value[N-1-r:0], value[N-1:N-r]};
        end
    end

    always_comb begin
        term = '0;
        for (int r = 0; r < N; r++) begin
            if ((idx == IW'(r)) && gen_mask[r]) begin
                term = rot[r];
            end
        end
    end
endmodule

// File: rtl/cyc_bit_ctr.sv
// Walks the generator bit index 0..N-1 and flags the last bit.
module cyc_bit_ctr #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    assign last = (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (en) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    // R6: a full pass over the generator bits always restarts from bit 0
    p_idx_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last && !clr) |=> (idx == '0));
endmodule

// File: rtl/cyc_pow_fsm.sv
// Sequencer: accepts start, counts applied factors, announces completion.
module cyc_pow_fsm
    import cyc_pow_pkg::*;
#(
    parameter int KW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] exp_in,
    input  logic          last_bit,
    output logic          load,
    output logic          in_mul,
    output logic          factor_end,
    output logic          fin
);
    pow_state_e    st_q, st_d;
    logic [KW-1:0] k_q;
    logic [KW-1:0] step_q;
    logic          mul_end;

    assign mul_end = (st_q == ST_MUL) && last_bit &&
                     (({1'b0, step_q} + 1'b1) == {1'b0, k_q});

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = (exp_in == '0) ? ST_FIN : ST_MUL;
            ST_MUL:  if (mul_end) st_d = ST_FIN;
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register with operand and factor counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            k_q    <= '0;
            step_q <= '0;
        end else begin
            st_q <= st_d;
            if (load) begin
                k_q    <= exp_in;
                step_q <= '0;
            end else if (factor_end) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        load       = 1'b0;
        in_mul     = 1'b0;
        factor_end = 1'b0;
        fin        = 1'b0;
        unique case (st_q)
            ST_IDLE: load = start;
            ST_MUL: begin
                in_mul     = 1'b1;
                factor_end = last_bit;
            end
            ST_FIN:  fin = 1'b1;
            default: ;
        endcase
    end

    // R2: a zero exponent never enters the multiply loop
    p_zero_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MUL) |-> (k_q != '0));
    // R6: never applies more factors than requested
    p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MUL) |-> (step_q < k_q));
    // R9: the captured exponent is frozen while busy
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(k_q));
    // R7: the finish state lasts one cycle
    p_fin_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIN) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/cyc_ring_power.sv
// g(x)^k mod (x^N + 1) over GF(2), one generator bit per clock.
module cyc_ring_power #(
    parameter int N  = 9,
    parameter int KW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  gen_in,
    input  logic [KW-1:0] exp_in,
    output logic [N-1:0]  result,
    output logic          done
);
    localparam int           IW   = (N > 1) ? $clog2(N) : 1;
    localparam logic [N-1:0] UNIT = N'(1);

    logic          load, in_mul, factor_end, fin, last_bit;
    logic [IW-1:0] idx;
    logic [N-1:0]  gen_q, run_q, acc_q, term, acc_next;
    logic [N-1:0]  result_q;
    logic          done_q;

    cyc_pow_fsm #(.KW(KW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .exp_in     (exp_in),
        .last_bit   (last_bit),
        .load       (load),
        .in_mul     (in_mul),
        .factor_end (factor_end),
        .fin        (fin)
    );

    cyc_bit_ctr #(.N(N), .IW(IW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (in_mul),
        .idx   (idx),
        .last  (last_bit)
    );

    cyc_rot_term #(.N(N), .IW(IW)) u_term (
        .value    (run_q),
        .gen_mask (gen_q),
        .idx      (idx),
        .term     (term)
    );

    assign acc_next = acc_q ^ term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
            run_q <= '0;
            acc_q <= '0;
        end else if (load) begin
            gen_q <= gen_in;
            run_q <= UNIT;
            acc_q <= '0;
        end else if (in_mul) begin
            if (factor_end) begin
                run_q <= acc_next;
                acc_q <= '0;
            end else begin
                acc_q <= acc_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) result_q <= run_q;
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the published result moves only together with done
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    // R9: the captured generator is frozen unless a start is accepted
    p_gen_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(gen_q));
    // R6: the accumulator is empty at the start of every factor
    p_acc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mul && factor_end) |=> (acc_q == '0));
endmodule

// File: tb/test_cyc_ring_power.sv
module test_cyc_ring_power;
    localparam int N  = 9;
    localparam int KW = 6;
    localparam int NV = 9;

    // vector: {generator, exponent, expected}
    localparam logic [N+KW+N-1:0] VEC [NV] = '{
        {9'h0AD, 6'd2,  9'h073},   // R4
        {9'h0AD, 6'd7,  9'h010},   // R4
        {9'h0AD, 6'd63, 9'h001},   // R5
        {9'h0AD, 6'd14, 9'h100},   // R5
        {9'h0AD, 6'd21, 9'h008},   // R5
        {9'h0AD, 6'd1,  9'h0AD},   // R3
        {9'h0D7, 6'd1,  9'h0D7},   // R3
        {9'h0AD, 6'd0,  9'h001},   // R2
        {9'h000, 6'd5,  9'h000}    // R4
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [N-1:0]  gen_in = '0;
    logic [KW-1:0] exp_in = '0;
    logic [N-1:0]  result;
    logic          done;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    cyc_ring_power #(.N(N), .KW(KW)) i_cyc_ring_power (
        .clk(clk), .rst_n(rst_n), .start(start),
        .gen_in(gen_in), .exp_in(exp_in), .result(result), .done(done)
    );

    // independent model: full product, then fold the upper half onto the lower
    function automatic logic [N-1:0] ring_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [2*N-1:0] p = '0;
        for (int i = 0; i < N; i++) if (b[i]) p = p ^ ({{N{1'b0}}, a} << i);
        return p[N-1:0] ^ p[2*N-1:N];
    endfunction

    function automatic logic [N-1:0] ring_pow(input logic [N-1:0] g, input int k);
        logic [N-1:0] r = N'(1);
        for (int i = 0; i < k; i++) r = ring_mul(r, g);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge where done is seen
    task automatic run_pow(input logic [N-1:0] g, input int k,
                           output logic [N-1:0] res, output int lat);
        start = 1'b1; gen_in = g; exp_in = KW'(k);
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (lat < 2000) begin
            @(posedge clk); @(negedge clk);
            lat++;
            if (done) break;
        end
        res = result;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] res;
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(result == '0, "R1 result", result, 0);
        check(done == 1'b0, "R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [N-1:0] g, e;
            int k;
            g = VEC[v][N+KW+N-1:KW+N];
            k = int'(VEC[v][KW+N-1:N]);
            e = VEC[v][N-1:0];
            run_pow(g, k, res, lat);
            check(res == e, "R4 vector result", res, e);
            check(lat == k * N + 1, "R6 latency", lat, k * N + 1);
        end

        // R4: back-to-back starts from the done cycle, model-computed
        for (int k = 3; k < 40; k += 9) begin
            run_pow(9'h0D7, k, res, lat);
            check(res == ring_pow(9'h0D7, k), "R4 model", res, ring_pow(9'h0D7, k));
            check(lat == k * N + 1, "R6 latency back-to-back", lat, k * N + 1);
        end

        // R8: operand changes without start leave result and done untouched
        begin
            logic [N-1:0] held;
            bit ok;
            held = result;
            ok = 1'b1;
            for (int c = 0; c < 30; c++) begin
                gen_in = N'(c * 37); exp_in = KW'(c);
                @(posedge clk); @(negedge clk);
                if (result != held || done) ok = 1'b0;
            end
            check(ok, "R8 hold", result, held);
        end

        // R9: start and new operands while busy are ignored
        start = 1'b1; gen_in = 9'h0AD; exp_in = 6'd14;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (lat < 2000) begin
            @(posedge clk); @(negedge clk);
            lat++;
            if (lat == 20 || lat == 126) begin
                start = 1'b1; gen_in = 9'h1FF; exp_in = 6'd3;
            end else begin
                start = 1'b0; gen_in = 9'h155;
            end
            if (done) break;
        end
        check(result == 9'h100, "R9 busy start result", result, 9'h100);
        check(lat == 14 * N + 1, "R9 busy start latency", lat, 14 * N + 1);

        // R9/R7: start held high: done pulses 1 cycle wide, k*N+2 apart
        @(negedge clk);
        start = 1'b1; gen_in = 9'h0AD; exp_in = 6'd1;
        begin
            int t = 0, first = -1, second = -1, width = 0;
            while (t < 200 && second < 0) begin
                @(posedge clk); @(negedge clk);
                t++;
                if (done) begin
                    width++;
                    if (first < 0) first = t; else second = t;
                end
            end
            start = 1'b0;
            check(second - first == N + 2, "R9 restart spacing", second - first, N + 2);
            check(width == 2, "R7 single-cycle done", width, 2);
            check(result == 9'h0AD, "R3 repeated k=1", result, 9'h0AD);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule